// File: doc/BRIEF.md
# Serial GPIO Chain Master

This block turns four wires into up to eighty output lines and eighty input lines. It shifts an output latch out on a serial data pin and shifts an input chain in on a second pin. Both use a divided serial clock. An active-low load strobe opens each frame. External shift-register chips sit on the other side of these wires. On the strobe they latch the previous outputs and capture their parallel inputs.

Software reaches the block through a plain synchronous register port. A control word sets the enable, the chain length in bytes and the clock divider. There are three kinds of per-bank registers. The value bank reads the sampled inputs, and writing it sets the outputs. The read-back bank returns the output latch, so a read-modify-write of the outputs is safe. The tolerance bank marks output lines that must survive a watchdog reset.

Top module: `sgc_chain_master`

## Requirements
- R1: The control word sits at address 0. It holds enable in bit 0, byte count in bits 9:6 and divider in bits 31:16. After system reset it reads 0x00020040: disabled, one byte, divider 1.
- R2: The divider field reads back shifted left by one bit within its 16 bits. A written 5 reads 10, and a written 0x8001 reads 0x0002.
- R3: sclk_o has a period of 2*(divider+1) clock cycles, low for the first half and high for the second. A written divider of 0 is stored and used as 1.
- R4: A written byte count of 0 is stored as 1, and any value above 10 is stored as 10. The chain is 8*bytes lines long (N).
- R5: Each frame begins with load_n_o low for one full serial period, starting with sclk_o low. N bit periods follow with load_n_o high, and then the next frame starts.
- R6: In bit period k (1..N), sdo_o carries output line N-k, so the highest line goes first. sdo_o changes only at the falling sclk_o edge that starts the period, or when the latch is written.
- R7: sdi_i is sampled at each rising sclk_o edge of a bit period. When a frame ends, the sampled register takes the new bits: the first bit received goes to line N-1 and the last to line 0. Lines N and above read 0. The sampled register changes only as load_n_o goes low.
- R8: The value banks are at addresses 1..3. A read returns sampled inputs and a write sets the output latch. The read-back banks at 4..6 return the latch. The tolerance banks at 7..9 are read/write. Line L maps to bank L/32, bit L%32. Lines 80 and above read 0 and ignore writes. Unmapped addresses read 0.
- R9: A high wdt_rst_i cycle clears every latch bit whose tolerance bit is 0 and clears the tolerance register. The control word and sampled inputs are kept. The watchdog reset takes priority over a write in the same cycle.
- R10: rst_ni low clears the latch, tolerance and sampled registers and returns the control word to its reset value.
- R11: While disabled, sclk_o is 0, load_n_o is 1 and sdo_o is 0. Setting enable starts at once with a load period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wdt_rst_i | input | 1 | Synchronous watchdog reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| sclk_o | output | 1 | Serial clock |
| load_n_o | output | 1 | Active-low frame load strobe |
| sdo_o | output | 1 | Serial output data |
| sdi_i | input | 1 | Serial input data |

## Verification
The bench drives sdi_i from a model of an external input chain that reloads on the strobe. It then reads the value banks back against that chain. A reversed bit order or an off-by-one frame length would show up as rotated or shifted sampled data. The bench also shrinks the chain in the middle of a frame. A slot counter that failed to wrap would hang the frame or drive sdo_o from the wrong line. It programs zero and oversize fields, so a missing clamp would give a zero divider or a chain longer than ten bytes. It fires the watchdog reset with mixed tolerance bits. Clearing too much or too little shows up as wrong read-back words or as a tolerance register that does not clear.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int EN_BIT    = 0;
  localparam int BYTES_LSB = 6;
  localparam int BYTES_W   = 4;
  localparam int DIV_LSB   = 16;
  localparam int DIV_W     = 16;

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic [BYTES_W-1:0] nbytes;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/sgc_clkgen.sv
module sgc_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] hcnt_q;
  logic             ph_q;
  logic             tick;

  // half period ends after div+1 cycles
  assign tick   = en_i && (hcnt_q >= div_i);
  assign rise_o = tick && !ph_q;
  assign fall_o = tick && ph_q;
  assign sclk_o = en_i && ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      ph_q   <= 1'b0;
    end else if (!en_i) begin
      hcnt_q <= '0;
      ph_q   <= 1'b0;
    end else if (tick) begin
      hcnt_q <= '0;
      ph_q   <= !ph_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sgc_shifter.sv
module sgc_shifter #(
  parameter int LINES   = 80,
  parameter int BYTES_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [BYTES_W-1:0] nbytes_i,
  input  logic [LINES-1:0]   latch_i,
  input  logic               sdi_i,
  input  logic               rise_i,
  input  logic               fall_i,
  output logic [LINES-1:0]   smp_o,
  output logic               load_n_o,
  output logic               sdo_o
);
  localparam int SLOT_W = BYTES_W + 3;

  logic [SLOT_W-1:0] slot_q, nlines, idx;
  logic [LINES-1:0]  cap_q, smp_q, mask;
  logic              bit_ok;

  assign nlines = {nbytes_i, 3'b000};
  assign idx    = nlines - slot_q;
  assign bit_ok = (slot_q != '0) && (slot_q <= nlines);

  always_comb begin
    for (int i = 0; i < LINES; i++) mask[i] = SLOT_W'(i) < nlines;
  end

  assign load_n_o = !(en_i && slot_q == '0);
  assign sdo_o    = en_i && bit_ok && latch_i[idx];
  assign smp_o    = smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cap_q  <= '0;
      smp_q  <= '0;
    end else if (!en_i) begin
      slot_q <= '0;
    end else begin
      if (rise_i && slot_q != '0) cap_q <= {cap_q[LINES-2:0], sdi_i};
      if (fall_i) begin
        // >= also wraps a frame left long by a shrink of the byte count
        if (slot_q >= nlines) begin
          slot_q <= '0;
          smp_q  <= cap_q & mask;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  // R7
  smp_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(smp_q) |-> !load_n_o);
endmodule

// File: rtl/sgc_regs.sv
module sgc_regs import sgc_pkg::*; #(
  parameter int LINES     = 80,
  parameter int MAX_BYTES = 10,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LINES-1:0]  smp_i,
  output ctrl_t             ctrl_o,
  output logic [LINES-1:0]  latch_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NBANKS   = (LINES + DATA_W - 1) / DATA_W;
  localparam int PAD_W    = NBANKS * DATA_W;
  localparam int VAL_BASE = 1;
  localparam int RB_BASE  = VAL_BASE + NBANKS;
  localparam int TOL_BASE = RB_BASE + NBANKS;
  localparam logic [BYTES_W-1:0] MAX_NB = BYTES_W'(MAX_BYTES);

  ctrl_t              ctrl_q, ctrl_d;
  logic [LINES-1:0]   latch_q, latch_d, tol_q, tol_d;
  logic [PAD_W-1:0]   latch_pad, tol_pad, smp_pad;
  logic [BYTES_W-1:0] wb;
  logic [DIV_W-1:0]   wd;

  assign wb      = wdata_i[BYTES_LSB +: BYTES_W];
  assign wd      = wdata_i[DIV_LSB +: DIV_W];
  assign smp_pad = PAD_W'(smp_i);

  always_comb begin
    ctrl_d    = ctrl_q;
    latch_d   = latch_q;
    tol_d     = tol_q;
    latch_pad = PAD_W'(latch_q);
    tol_pad   = PAD_W'(tol_q);
    if (wdt_rst_i) begin
      latch_d = latch_q & tol_q;
      tol_d   = '0;
    end else if (wr_en_i) begin
      if (addr_i == '0) begin
        ctrl_d.en     = wdata_i[EN_BIT];
        ctrl_d.nbytes = (wb == '0) ? BYTES_W'(1) : ((wb > MAX_NB) ? MAX_NB : wb);
        ctrl_d.div    = (wd == '0) ? DIV_W'(1) : wd;
      end
      for (int b = 0; b < NBANKS; b++) begin
        if (addr_i == ADDR_W'(VAL_BASE + b)) latch_pad[b*DATA_W +: DATA_W] = wdata_i;
        if (addr_i == ADDR_W'(TOL_BASE + b)) tol_pad[b*DATA_W +: DATA_W]   = wdata_i;
      end
      latch_d = latch_pad[LINES-1:0];
      tol_d   = tol_pad[LINES-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{div: DIV_W'(1), nbytes: BYTES_W'(1), en: 1'b0};
      latch_q <= '0;
      tol_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      latch_q <= latch_d;
      tol_q   <= tol_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[EN_BIT]                 = ctrl_q.en;
      rdata_o[BYTES_LSB +: BYTES_W]   = ctrl_q.nbytes;
      rdata_o[DIV_LSB +: DIV_W]       = {ctrl_q.div[DIV_W-2:0], 1'b0};
    end
    for (int b = 0; b < NBANKS; b++) begin
      if (addr_i == ADDR_W'(VAL_BASE + b)) rdata_o = smp_pad[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(RB_BASE + b))  rdata_o = PAD_W'(latch_q) >> (b*DATA_W);
      if (addr_i == ADDR_W'(TOL_BASE + b)) rdata_o = PAD_W'(tol_q) >> (b*DATA_W);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign latch_o = latch_q;

  // R9
  wdt_tol_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> tol_q == '0);
  // R9
  wdt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> latch_q == ($past(latch_q) & $past(tol_q)));
  // R4
  nbytes_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.nbytes != '0) && (ctrl_q.nbytes <= MAX_NB));
endmodule

// File: rtl/sgc_chain_master.sv
module sgc_chain_master import sgc_pkg::*; #(
  parameter int MAX_BYTES = 10,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              load_n_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int LINES = MAX_BYTES * 8;

  ctrl_t            ctrl;
  logic [LINES-1:0] latch, smp;
  logic             rise, fall;

  sgc_regs #(.LINES(LINES), .MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wdt_rst_i, .wr_en_i, .addr_i, .wdata_i,
    .smp_i(smp), .ctrl_o(ctrl), .latch_o(latch), .rdata_o
  );

  sgc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .en_i(ctrl.en), .div_i(ctrl.div),
    .rise_o(rise), .fall_o(fall), .sclk_o
  );

  sgc_shifter #(.LINES(LINES), .BYTES_W(BYTES_W)) u_shifter (
    .clk_i, .rst_ni, .en_i(ctrl.en), .nbytes_i(ctrl.nbytes), .latch_i(latch),
    .sdi_i, .rise_i(rise), .fall_i(fall), .smp_o(smp), .load_n_o, .sdo_o
  );

  // R5
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_n_o) |-> !sclk_o);
endmodule

// File: tb/sgc_chain_master_tb.sv
`timescale 1ns/1ps
module sgc_chain_master_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, wdt_rst_i = 1'b0, wr_en_i = 1'b0, sdi_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        sclk_o, load_n_o, sdo_o;

  always #2 clk_i = ~clk_i;

  sgc_chain_master u_dut (.*);

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // reference model
  localparam logic [95:0] LMASK = {16'h0, {80{1'b1}}};
  logic        m_en, m_ph;
  logic [3:0]  m_bytes;
  logic [15:0] m_div, m_hc;
  int          m_slot;
  logic [95:0] m_latch, m_tol, tmp;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= 0; m_bytes <= 1; m_div <= 1; m_hc <= 0; m_ph <= 0; m_slot <= 0;
      m_latch <= '0; m_tol <= '0;
    end else begin
      if (!m_en) begin
        m_hc <= 0; m_ph <= 0; m_slot <= 0;
      end else if (m_hc >= m_div) begin
        m_hc <= 0; m_ph <= !m_ph;
        if (m_ph) m_slot <= (m_slot >= m_bytes * 8) ? 0 : m_slot + 1;
      end else m_hc <= m_hc + 1;
      if (wdt_rst_i) begin
        m_latch <= m_latch & m_tol; m_tol <= '0;
      end else if (wr_en_i) begin
        if (addr_i == 0) begin
          m_en <= wdata_i[0];
          m_bytes <= (wdata_i[9:6] == 0) ? 4'd1 : (wdata_i[9:6] > 10 ? 4'd10 : wdata_i[9:6]);
          m_div <= (wdata_i[31:16] == 0) ? 16'd1 : wdata_i[31:16];
        end else if (addr_i >= 1 && addr_i <= 3) begin
          tmp = m_latch; tmp[(addr_i-1)*32 +: 32] = wdata_i; m_latch <= tmp & LMASK;
        end else if (addr_i >= 7 && addr_i <= 9) begin
          tmp = m_tol; tmp[(addr_i-7)*32 +: 32] = wdata_i; m_tol <= tmp & LMASK;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int n;
      logic e_sdo;
      n = m_bytes * 8;
      e_sdo = (m_en && m_slot != 0 && m_slot <= n) ? m_latch[n - m_slot] : 1'b0;
      chk(sclk_o == (m_en & m_ph), "R3 sclk_o", 32'(sclk_o), 32'(m_en & m_ph));
      chk(load_n_o == !(m_en && m_slot == 0), "R5 load_n_o", 32'(load_n_o), 32'(!(m_en && m_slot == 0)));
      chk(sdo_o == e_sdo, "R6 sdo_o", 32'(sdo_o), 32'(e_sdo));
    end
  end

  // external input chain
  logic [79:0] ext_in = '0;
  int  dev_idx = -1;
  logic prev_sclk = 0, prev_load = 1;
  always @(negedge clk_i) begin
    if (!load_n_o) dev_idx = m_bytes * 8 - 1;
    else if (prev_load && prev_sclk && !sclk_o) dev_idx = dev_idx - 1;
    sdi_i <= (dev_idx >= 0) ? ext_in[dev_idx] : 1'b0;
    prev_sclk = sclk_o;
    prev_load = load_n_o;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [31:0] exp, input string what);
    logic [31:0] d;
    rd(a, d);
    chk(d === exp, what, d, exp);
  endtask

  task automatic meas(output int p);
    p = 0;
    while (sclk_o !== 1'b0) @(negedge clk_i);
    while (sclk_o !== 1'b1) @(negedge clk_i);
    while (sclk_o !== 1'b0) begin @(negedge clk_i); p++; end
    while (sclk_o !== 1'b1) begin @(negedge clk_i); p++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p;
    logic [31:0] d;
    idle(3);
    rst_ni = 1;
    // R1 R10 reset state, R11 idle pins
    rchk(0, 32'h0002_0040, "R1 ctrl reset");
    chk(sclk_o == 0 && load_n_o == 1 && sdo_o == 0, "R11 idle pins",
        {29'b0, sclk_o, load_n_o, sdo_o}, 32'h2);
    rchk(1, 32'h0, "R10 sampled reset");

    // R8 map
    wr(1, 32'hA5A5_0F0F); wr(2, 32'h1234_5678); wr(3, 32'hFFFF_BEEF);
    rchk(4, 32'hA5A5_0F0F, "R8 readback bank0");
    rchk(5, 32'h1234_5678, "R8 readback bank1");
    rchk(6, 32'h0000_BEEF, "R8 lines above 79");
    rchk(1, 32'h0, "R8 value reads sampled");
    rchk(12, 32'h0, "R8 unmapped");
    chk(sdo_o == 0 && load_n_o == 1, "R11 disabled with data", {30'b0, load_n_o, sdo_o}, 32'h2);

    // R4 clamp
    wr(0, 32'h0001_0000);
    rd(0, d); chk(d[9:6] == 4'd1, "R4 zero bytes", 32'(d[9:6]), 32'd1);
    wr(0, 32'h0001_03C0);
    rd(0, d); chk(d[9:6] == 4'd10, "R4 oversize bytes", 32'(d[9:6]), 32'd10);
    // R2 shifted divider
    wr(0, 32'h0005_0040);
    rd(0, d); chk(d[31:16] == 16'd10, "R2 div 5", 32'(d[31:16]), 32'd10);
    wr(0, 32'h8001_0040);
    rd(0, d); chk(d[31:16] == 16'd2, "R2 div msb", 32'(d[31:16]), 32'd2);
    wr(0, 32'h0000_0040);
    rd(0, d); chk(d[31:16] == 16'd2, "R3 div zero", 32'(d[31:16]), 32'd2);

    // R7 two bytes, div 1
    ext_in = 80'hC3A5_9F01_7E24_D8B6_5A3C;
    wr(0, 32'h0001_0081);
    meas(p); chk(p == 4, "R3 period div1", p, 4);
    idle(300);
    rchk(1, {16'h0, ext_in[15:0]}, "R7 two byte capture");
    rchk(2, 32'h0, "R7 lines above N");

    // R7 ten bytes, div 3
    wr(0, 32'h0003_0281);
    meas(p); chk(p == 8, "R3 period div3", p, 8);
    idle(3000);
    rchk(1, ext_in[31:0], "R7 full chain bank0");
    rchk(2, ext_in[63:32], "R7 full chain bank1");
    rchk(3, {16'h0, ext_in[79:64]}, "R7 full chain bank2");

    // shrink mid-frame, R3 div0 -> 1, R7 masking
    ext_in = 80'h0F1E_2D3C_4B5A_6978_8796;
    idle(37);
    wr(0, 32'h0000_0041);
    meas(p); chk(p == 4, "R3 period div0", p, 4);
    idle(200);
    rchk(1, {24'h0, ext_in[7:0]}, "R7 one byte capture");
    rchk(2, 32'h0, "R7 masked bank1");
    rchk(3, 32'h0, "R7 masked bank2");

    // R9 watchdog
    wr(7, 32'h0000_FFFF); wr(8, 32'h0); wr(9, 32'h0000_FFFF);
    @(negedge clk_i); wdt_rst_i = 1; wr_en_i = 1; addr_i = 4'd7; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i); wdt_rst_i = 0; wr_en_i = 0;
    rchk(4, 32'h0000_0F0F, "R9 tolerant bits kept");
    rchk(5, 32'h0, "R9 bank1 cleared");
    rchk(6, 32'h0000_BEEF, "R9 bank2 tolerant");
    rchk(7, 32'h0, "R9 tolerance cleared");
    rd(0, d); chk(d[0] == 1'b1, "R9 control kept", 32'(d[0]), 32'd1);
    rchk(1, {24'h0, ext_in[7:0]}, "R9 sampled kept");

    // R6 latch writes while running, longer chain
    wr(0, 32'h0002_0101);
    wr(1, 32'h8000_0001); idle(120);
    wr(1, 32'h0F0F_F0F0); idle(400);

    // R10 system reset mid-run
    @(negedge clk_i); rst_ni = 0; idle(2); rst_ni = 1;
    rchk(0, 32'h0002_0040, "R10 ctrl");
    rchk(4, 32'h0, "R10 latch");
    rchk(1, 32'h0, "R10 sampled");
    rchk(7, 32'h0, "R10 tolerance");
    chk(sclk_o == 0 && load_n_o == 1, "R11 after reset", {30'b0, sclk_o, load_n_o}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule